// File: doc/BRIEF.md
# Two-Read One-Write Register File with Write Bypass

This block is the general-purpose register storage of a 32-bit load/store processor. It holds 32 registers of 32 bits each. Two read ports, each addressed by its own 5-bit register number, return register values combinationally during operand fetch. One write port stores a 32-bit result into a chosen register on the rising clock edge while its write-enable is high.

Register number 0 is a constant: it always reads as zero, and anything written to it is dropped. A write and a read of the same register can fall in the same cycle. In that case the read port returns the value being written, not the old stored value, so the instruction behind the writer sees fresh data without a stall.

An active-low reset blocks writes and bypass while it is held low. It does not clear the stored registers.

Top module: `regfile_bypass`

## Requirements
- R1: The file holds NUM_REGS (default 32) registers of DATA_W (default 32) bits, selected by a register number of ADDR_W = clog2(NUM_REGS) bits (default 5).
- R2: Each read port combinationally returns the stored value of the register it addresses when no qualifying write to that register is present in the same cycle.
- R3: With wr_en high and rst_n high, the register addressed by wr_addr takes wr_data on the rising clock edge. Later reads of it return the most recent such value.
- R4: With wr_en low, no register changes at the clock edge and neither read port forwards wr_data.
- R5: A read of register 0 returns zero on both ports at all times, including a cycle in which a write to register 0 is presented.
- R6: When wr_en and rst_n are high and wr_addr equals a nonzero read address, that read port outputs wr_data in the same cycle.
- R7: The two read ports may address the same register in the same cycle. Each applies the zero and bypass rules on its own, and both then return the same value.
- R8: A write addressed to register 0 is discarded, so later reads of register 0 still return zero.
- R9: While rst_n is low, writes are neither stored nor forwarded. Reset does not clear the stored registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes and bypass while low |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Value returned on read port A |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Value returned on read port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Destination register number |
| wr_data | input | 32 | Data to write |

## Verification
A write and a read of the same register can fall in the same cycle, and so can a write to register 0 and a read of it. The bench provokes both cases by driving a write and matching read addresses on both ports together. It samples the read data before the clock edge and expects the incoming data for a nonzero register, or zero for register 0. After the edge it reads the register again to confirm the value was stored, or for register 0 discarded. A randomized phase mixes these collisions with ordinary traffic and compares every read against a 32-entry reference array.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int unsigned RF_NUM_REGS = 32;
  localparam int unsigned RF_DATA_W   = 32;
  localparam int unsigned RF_ADDR_W   = $clog2(RF_NUM_REGS);
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned NUM_REGS = regfile_pkg::RF_NUM_REGS,
  parameter int unsigned DATA_W   = regfile_pkg::RF_DATA_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en_q,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

  // Register 0 is a constant; no storage is built for it (R5, R8).
  assign regs_o[0] = '0;

  for (genvar gi = 1; gi < NUM_REGS; gi++) begin : g_reg
    logic              sel_we;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] q_nxt;

    always_comb begin
      sel_we = wr_en_q && (wr_addr == ADDR_W'(gi));
      q_nxt  = sel_we ? wr_data : q;
    end

    // Clock-enabled storage; contents are not reset.
    always_ff @(posedge clk) begin
      if (sel_we) q <= q_nxt;
    end

    assign regs_o[gi] = q;

    // R3: a selected write lands exactly one edge later.
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_q && wr_addr == ADDR_W'(gi)) |=> (q == $past(wr_data)));
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NUM_REGS = regfile_pkg::RF_NUM_REGS,
  parameter int unsigned DATA_W   = regfile_pkg::RF_DATA_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic                             wr_en_q,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [DATA_W-1:0]                rd_data
);

  logic hit_zero;
  logic hit_fwd;

  always_comb begin
    hit_zero = (rd_addr == '0);
    hit_fwd  = wr_en_q && (wr_addr == rd_addr);
    if (hit_zero)     rd_data = '0;        // zero rule wins over bypass
    else if (hit_fwd) rd_data = wr_data;
    else              rd_data = regs_i[rd_addr];
  end

endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass #(
  parameter int unsigned NUM_REGS = regfile_pkg::RF_NUM_REGS,
  parameter int unsigned DATA_W   = regfile_pkg::RF_DATA_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int unsigned NUM_RD = 2;

  logic                            wr_en_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;

  // Writes and bypass are qualified by reset (R9).
  assign wr_en_q = wr_en && rst_n;

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_q (wr_en_q),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_o  (regs)
  );

  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;

  for (genvar gp = 0; gp < NUM_RD; gp++) begin : g_port
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
      .regs_i  (regs),
      .rd_addr (rd_addr_v[gp]),
      .wr_en_q (wr_en_q),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_data (rd_data_v[gp])
    );
  end

  assign rd_data_a = rd_data_v[0];
  assign rd_data_b = rd_data_v[1];

  // R5: register 0 reads zero on both ports.
  a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

  // R6: same-cycle write is forwarded to a matching nonzero read.
  a_r6_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_addr_a != '0 && wr_addr == rd_addr_a) |-> (rd_data_a == wr_data));
  a_r6_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_addr_b != '0 && wr_addr == rd_addr_b) |-> (rd_data_b == wr_data));

  // R7: both ports agree when they address the same register.
  a_r7_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

endmodule

// File: tb/regfile_bypass_bench.sv
module regfile_bypass_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] rd_data_a, rd_data_b, wr_data;
  logic        wr_en;

  int checks = 0;
  int errors = 0;
  logic [31:0] ref_m [NR];

  regfile_bypass u_regfile_bypass (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive on negedge; sample a quarter period later, before the next rising edge.
  task automatic drive(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    #(CLK_PERIOD/4);
  endtask

  function automatic logic [31:0] model(input logic we, input logic [4:0] wa,
                                        input logic [31:0] wd, input logic [4:0] ra);
    if (ra == 0) return 32'h0;
    if (we && wa == ra) return wd;
    return ref_m[ra];
  endfunction

  task automatic t_reset;
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    check("R5 reset zero A", rd_data_a, 32'h0);
    check("R5 reset zero B", rd_data_b, 32'h0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < NR; i++) begin
      drive(1'b1, 5'(i), 32'hA500_0000 + 32'(i) * 32'h0101_0101, 5'd0, 5'd0);
      if (i != 0) ref_m[i] = 32'hA500_0000 + 32'(i) * 32'h0101_0101;
    end
    for (int i = 0; i < NR; i++) begin
      drive(1'b0, 5'd0, 32'hFFFF_FFFF, 5'(i), 5'(NR - 1 - i));
      check(i == 0 ? "R8 reg0 after write A" : "R3 stored A", rd_data_a, ref_m[i]);
      check("R2 stored B", rd_data_b, ref_m[NR - 1 - i]);
    end
  endtask

  task automatic t_bypass;
    drive(1'b1, 5'd9, 32'hDEAD_BEEF, 5'd9, 5'd9);
    check("R6 bypass A", rd_data_a, 32'hDEAD_BEEF);
    check("R7 bypass B same reg", rd_data_b, 32'hDEAD_BEEF);
    ref_m[9] = 32'hDEAD_BEEF;
    drive(1'b1, 5'd10, 32'h1234_5678, 5'd10, 5'd9);
    check("R6 bypass A only", rd_data_a, 32'h1234_5678);
    check("R2 other port stored", rd_data_b, 32'hDEAD_BEEF);
    ref_m[10] = 32'h1234_5678;
    drive(1'b0, 5'd0, 32'h0, 5'd10, 5'd10);
    check("R3 latest value", rd_data_a, 32'h1234_5678);
  endtask

  task automatic t_no_write;
    drive(1'b0, 5'd12, 32'h0BAD_0BAD, 5'd12, 5'd12);
    check("R4 no bypass A", rd_data_a, ref_m[12]);
    check("R4 no bypass B", rd_data_b, ref_m[12]);
    drive(1'b0, 5'd0, 32'h0, 5'd12, 5'd0);
    check("R4 unchanged", rd_data_a, ref_m[12]);
  endtask

  task automatic t_zero_write;
    drive(1'b1, 5'd0, 32'hCAFE_F00D, 5'd0, 5'd0);
    check("R5 zero during write A", rd_data_a, 32'h0);
    check("R5 zero during write B", rd_data_b, 32'h0);
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    check("R8 discarded", rd_data_a, 32'h0);
  endtask

  task automatic t_reset_block;
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h5555_AAAA;
    rd_addr_a = 5'd5; rd_addr_b = 5'd6;
    #(CLK_PERIOD/4);
    check("R9 no bypass in reset", rd_data_a, ref_m[5]);
    @(negedge clk);
    wr_en = 1'b0; rst_n = 1'b1;
    #(CLK_PERIOD/4);
    check("R9 no write in reset", rd_data_a, ref_m[5]);
    check("R9 not cleared", rd_data_b, ref_m[6]);
  endtask

  task automatic t_random;
    for (int k = 0; k < 400; k++) begin
      logic        we = 1'($urandom);
      logic [4:0]  wa = 5'($urandom);
      logic [31:0] wd = $urandom;
      logic [4:0]  ra = ($urandom % 4 == 0) ? wa : 5'($urandom);
      logic [4:0]  rb = ($urandom % 3 == 0) ? wa : 5'($urandom);
      drive(we, wa, wd, ra, rb);
      check("R6 random A", rd_data_a, model(we, wa, wd, ra));
      check("R7 random B", rd_data_b, model(we, wa, wd, rb));
      if (we && wa != 0) ref_m[wa] = wd;
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;
    for (int i = 0; i < NR; i++) ref_m[i] = 32'h0;
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk) rst_n = 1'b1;
    t_fill;       // R1: all 32 registers written and read back
    t_bypass;
    t_no_write;
    t_zero_write;
    t_reset_block;
    t_random;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule